// File: doc/BRIEF.md
# I2C SCL Rate Generator

This block turns the peripheral clock into SCL phase timing for an I2C byte controller. An 11-bit divisor arrives in two parts, a 5-bit low part and a 6-bit high part, next to a speed-mode bit and an enable. While it is enabled, the block runs a repeating SCL cycle. It drives the line low for a set count. It then releases the line and waits until the line actually reads high. After that it counts the high phase and starts the next low phase.

The byte controller gets three one-cycle strobes. One marks the start of each low phase, the moment to change SDA. One marks the release of SCL. One marks the middle of the high phase, the moment to sample SDA. A device that holds SCL low after the release stretches the cycle, and the high phase is still counted in full once the line is seen high.

Standard mode gives equal low and high phases. Fast mode keeps the low phase and roughly halves the high phase, so the period is about three quarters of the standard one and the duty is about 2:1 low to high. After enable rises, the block waits a fixed settling interval before it drives the line. All pins are plain control and status signals with no handshake. `scl_in_i` is expected to be synchronised to `clk` already.

Top module: `i2c_scl_rate_gen`

## Requirements
- R1: The divisor is CS = {cs_hi_i, cs_lo_i}: cs_hi_i supplies CS bits [10:5] and cs_lo_i supplies CS bits [4:0].
- R2: With fast_i = 0, scl_low_o stays 1 for CS+2 cycles, and SCL is then released for CS+2 cycles once scl_in_i reads high.
- R3: With fast_i = 1, the low phase lasts CS+2 cycles and the released-high phase lasts floor((CS+1)/2)+1 cycles.
- R4: After the release, every cycle in which scl_in_i reads 0 lengthens the period by exactly one cycle. The high-phase count starts with the first cycle in which scl_in_i reads 1.
- R5: After enable_i is sampled high, scl_low_o first rises exactly SETTLE_CYCLES (default 100) clock edges later.
- R6: When enable_i is sampled low, scl_low_o is 0 from the next cycle on, and a later enable starts the settling wait again.
- R7: fall_stb_o is 1 for exactly one cycle in each low phase: its first cycle.
- R8: rise_stb_o is 1 for exactly one cycle in each released phase: the first cycle after scl_low_o falls.
- R9: sample_stb_o is 1 for exactly one cycle in each high phase. That cycle is at index floor(H/2), counted from 0 at the first cycle with scl_in_i high, where H is the high-phase length.
- R10: During and right after reset, scl_low_o and all three strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Runs the generator; clearing it stops and resets it |
| fast_i | input | 1 | 1 selects fast-mode timing, 0 standard |
| cs_lo_i | input | CS_LO_W | Divisor bits [4:0] |
| cs_hi_i | input | CS_HI_W | Divisor bits [10:5] |
| scl_in_i | input | 1 | Synchronised SCL line level |
| scl_low_o | output | 1 | 1 pulls SCL low, 0 releases it |
| fall_stb_o | output | 1 | First cycle of a low phase |
| rise_stb_o | output | 1 | First cycle after SCL is released |
| sample_stb_o | output | 1 | Middle of the high phase, for sampling SDA |

## Verification
The assertions assume three things about the inputs. First, `scl_in_i` is already synchronous to `clk`. Second, it reads 0 whenever the block itself pulls the line low. Third, the divisor and the mode bit change only while the generator is disabled, so the registered phase lengths are steady across a run.

The stimulus keeps within these limits:
- It derives `scl_in_i` from a wired-AND model of the block's own drive and a peripheral that holds the line low for a programmed number of cycles after each release.
- It writes the divisor and the mode bit only while `enable_i` is low.

// File: rtl/i2c_sclgen_pkg.sv
package i2c_sclgen_pkg;
  // Line phase of the generator
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,  // disabled or settling, line released
    PH_LOW  = 2'd1,  // pulling SCL low
    PH_WAIT = 2'd2,  // released, waiting for the line to read high
    PH_HIGH = 2'd3   // counting the high phase
  } scl_phase_e;
endpackage

// File: rtl/i2c_sclgen_divsel.sv
module i2c_sclgen_divsel #(
  parameter int CS_LO_W = 5,
  parameter int CS_HI_W = 6,
  parameter int LEN_W   = CS_LO_W + CS_HI_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fast_i,
  input  logic [CS_LO_W-1:0] cs_lo_i,
  input  logic [CS_HI_W-1:0] cs_hi_i,
  output logic [LEN_W-1:0]   low_len_o,
  output logic [LEN_W-1:0]   high_len_o
);
  localparam int CS_W = CS_LO_W + CS_HI_W;

  logic [CS_W-1:0]  cs;
  logic [LEN_W-1:0] n_plus1;
  logic [LEN_W-1:0] low_nx;
  logic [LEN_W-1:0] high_nx;

  assign cs      = {cs_hi_i, cs_lo_i};
  assign n_plus1 = LEN_W'(cs) + LEN_W'(1);
  assign low_nx  = n_plus1 + LEN_W'(1);
  // fast mode halves the high phase; standard keeps it equal to the low phase
  assign high_nx = fast_i ? ((n_plus1 >> 1) + LEN_W'(1)) : low_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_len_o  <= LEN_W'(2);
      high_len_o <= LEN_W'(2);
    end else begin
      low_len_o  <= low_nx;
      high_len_o <= high_nx;
    end
  end

  // R2
  std_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_i |=> (high_len_o == low_len_o));
  // R3
  fast_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fast_i |=> (high_len_o < low_len_o));
endmodule

// File: rtl/i2c_sclgen_settle.sv
module i2c_sclgen_settle #(
  parameter int SETTLE_CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic rdy_o
);
  generate
    if (SETTLE_CYCLES == 0) begin : g_nowait
      assign rdy_o = en_i;
    end else begin : g_wait
      localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            cnt_q <= '0;
        else if (!en_i)                        cnt_q <= '0;
        else if (cnt_q != CNT_W'(SETTLE_CYCLES)) cnt_q <= cnt_q + CNT_W'(1);
      end

      assign rdy_o = en_i && (cnt_q == CNT_W'(SETTLE_CYCLES));

      // R5
      ready_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o |-> $past(en_i));
    end
  endgenerate
endmodule

// File: rtl/i2c_sclgen_phase.sv
module i2c_sclgen_phase
  import i2c_sclgen_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             rdy_i,
  input  logic             scl_in_i,
  input  logic [LEN_W-1:0] low_len_i,
  input  logic [LEN_W-1:0] high_len_i,
  output logic             scl_low_o,
  output logic             fall_stb_o,
  output logic             rise_stb_o,
  output logic             sample_stb_o
);
  scl_phase_e       ph_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] low_last;
  logic [LEN_W-1:0] high_last;
  logic [LEN_W-1:0] half;

  assign low_last  = low_len_i - LEN_W'(1);
  assign high_last = high_len_i - LEN_W'(1);
  assign half      = high_len_i >> 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (!en_i) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (rdy_i) begin
          ph_q  <= PH_LOW;
          cnt_q <= '0;
        end
        PH_LOW: if (cnt_q == low_last) begin
          ph_q  <= PH_WAIT;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + LEN_W'(1);
        end
        PH_WAIT: if (scl_in_i) begin
          // this cycle is index 0 of the high phase
          if (high_len_i == LEN_W'(1)) begin
            ph_q  <= PH_LOW;
            cnt_q <= '0;
          end else begin
            ph_q  <= PH_HIGH;
            cnt_q <= LEN_W'(1);
          end
        end else begin
          cnt_q <= LEN_W'(1);  // marks stretch cycles after the first
        end
        PH_HIGH: if (cnt_q == high_last) begin
          ph_q  <= PH_LOW;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + LEN_W'(1);
        end
        default: begin
          ph_q  <= PH_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign scl_low_o    = (ph_q == PH_LOW);
  assign fall_stb_o   = (ph_q == PH_LOW) && (cnt_q == '0);
  assign rise_stb_o   = (ph_q == PH_WAIT) && (cnt_q == '0);
  assign sample_stb_o = ((ph_q == PH_WAIT) && scl_in_i && (half == '0)) ||
                        ((ph_q == PH_HIGH) && (cnt_q == half));

  // R7
  fall_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_low_o) |-> fall_stb_o);
  // R6
  release_on_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !scl_low_o);
  // R4
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_WAIT && !scl_in_i && en_i) |=> (ph_q == PH_WAIT && !scl_low_o));
  // R9
  sample_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb_o |-> (scl_in_i && !scl_low_o));
  // R2
  low_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_LOW) |-> (cnt_q < low_len_i));
endmodule

// File: rtl/i2c_scl_rate_gen.sv
module i2c_scl_rate_gen #(
  parameter int CS_LO_W       = 5,
  parameter int CS_HI_W       = 6,
  parameter int SETTLE_CYCLES = 100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable_i,
  input  logic               fast_i,
  input  logic [CS_LO_W-1:0] cs_lo_i,
  input  logic [CS_HI_W-1:0] cs_hi_i,
  input  logic               scl_in_i,
  output logic               scl_low_o,
  output logic               fall_stb_o,
  output logic               rise_stb_o,
  output logic               sample_stb_o
);
  localparam int LEN_W = CS_LO_W + CS_HI_W + 1;

  logic [LEN_W-1:0] low_len;
  logic [LEN_W-1:0] high_len;
  logic             rdy;

  i2c_sclgen_divsel #(
    .CS_LO_W(CS_LO_W),
    .CS_HI_W(CS_HI_W),
    .LEN_W  (LEN_W)
  ) u_divsel (
    .clk       (clk),
    .rst_n     (rst_n),
    .fast_i    (fast_i),
    .cs_lo_i   (cs_lo_i),
    .cs_hi_i   (cs_hi_i),
    .low_len_o (low_len),
    .high_len_o(high_len)
  );

  i2c_sclgen_settle #(
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_settle (
    .clk  (clk),
    .rst_n(rst_n),
    .en_i (enable_i),
    .rdy_o(rdy)
  );

  i2c_sclgen_phase #(
    .LEN_W(LEN_W)
  ) u_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (enable_i),
    .rdy_i       (rdy),
    .scl_in_i    (scl_in_i),
    .low_len_i   (low_len),
    .high_len_i  (high_len),
    .scl_low_o   (scl_low_o),
    .fall_stb_o  (fall_stb_o),
    .rise_stb_o  (rise_stb_o),
    .sample_stb_o(sample_stb_o)
  );
endmodule

// File: tb/i2c_scl_rate_gen_tb.sv
module i2c_scl_rate_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       fast = 1'b0;
  logic [4:0] cs_lo = '0;
  logic [5:0] cs_hi = '0;
  logic       scl_in;
  logic       scl_low, fall_stb, rise_stb, sample_stb;

  int hold_len = 0;
  int rel_cnt  = 0;
  int checks   = 0;
  int errors   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_scl_rate_gen u_dut (
    .clk(clk), .rst_n(rst_n), .enable_i(en), .fast_i(fast),
    .cs_lo_i(cs_lo), .cs_hi_i(cs_hi), .scl_in_i(scl_in),
    .scl_low_o(scl_low), .fall_stb_o(fall_stb),
    .rise_stb_o(rise_stb), .sample_stb_o(sample_stb)
  );

  // wired-AND line: own drive plus a peripheral that stretches for hold_len cycles
  always @(posedge clk) begin
    if (scl_low) rel_cnt <= 0;
    else         rel_cnt <= rel_cnt + 1;
  end
  assign scl_in = !scl_low && (rel_cnt >= hold_len);

  typedef struct {
    int    lo;
    int    wt;
    int    hi;
    string req;
  } exp_t;
  exp_t q[$];

  task automatic chk_eq(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // monitor state
  int seg = 0;
  int lo_n, wt_n, hi_n, samp_n, samp_pos, rise_n, fall_n, idle_n;
  int rise_first, fall_first;

  task automatic finish_period();
    exp_t e;
    if (q.size() == 0) return;
    e = q.pop_front();
    chk_eq(e.req, "low cycles", lo_n, e.lo);
    chk_eq("R4", "stretch cycles", wt_n, e.wt);
    chk_eq(e.req, "high cycles", hi_n, e.hi);
    chk_eq("R7", "fall strobes per low phase", fall_n, 1);
    chk_eq("R7", "fall strobe on first low cycle", fall_first, 1);
    chk_eq("R8", "rise strobes per release", rise_n, 1);
    chk_eq("R8", "rise strobe on first released cycle", rise_first, 1);
    chk_eq("R9", "sample strobes per high phase", samp_n, 1);
    chk_eq("R9", "sample strobe index", samp_pos, e.hi / 2);
  endtask

  always @(negedge clk) begin
    if (!rst_n || !en) begin
      seg    = 0;
      idle_n = 0;
    end else if (scl_low) begin
      if (seg == 0) chk_eq("R5", "settle cycles", idle_n, SETTLE);
      else if (seg == 3) finish_period();
      if (seg != 1) begin
        seg = 1; lo_n = 0; fall_n = 0; fall_first = int'(fall_stb);
      end
      lo_n++;
      if (fall_stb) fall_n++;
    end else if (seg == 0) begin
      idle_n++;
    end else begin
      if (seg == 1) begin
        seg = 2; wt_n = 0; hi_n = 0; samp_n = 0; samp_pos = -1;
        rise_n = 0; rise_first = int'(rise_stb);
      end
      if (rise_stb) rise_n++;
      if (scl_in) begin
        seg = 3;
        if (sample_stb) begin samp_n++; samp_pos = hi_n; end
        hi_n++;
      end else begin
        wt_n++;
      end
    end
  end

  // driver: program while disabled, push expected periods, run until consumed
  task automatic run_case(int clo, int chi, bit f, int hold, int nper, string req);
    int cs, lo, hi;
    @(negedge clk); #1;
    en = 1'b0; cs_lo = 5'(clo); cs_hi = 6'(chi); fast = f; hold_len = hold;
    repeat (3) @(negedge clk);
    #1;
    cs = chi * 32 + clo;
    lo = cs + 2;
    hi = f ? ((cs + 1) / 2) + 1 : cs + 2;
    for (int i = 0; i < nper; i++) q.push_back('{lo, hold, hi, req});
    en = 1'b1;
    while (q.size() != 0) @(negedge clk);
    @(negedge clk); #1;
    en = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    int bad;
    repeat (3) @(negedge clk);
    // R10 outputs idle in reset
    chk_eq("R10", "outputs during reset", int'({scl_low, fall_stb, rise_stb, sample_stb}), 0);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_eq("R10", "outputs after reset", int'({scl_low, fall_stb, rise_stb, sample_stb}), 0);

    run_case(3, 0, 1'b0, 0, 3, "R2");
    run_case(4, 0, 1'b1, 0, 3, "R3");
    run_case(0, 0, 1'b1, 0, 3, "R3");
    run_case(0, 1, 1'b0, 0, 2, "R1");
    run_case(3, 1, 1'b1, 0, 2, "R1");
    run_case(3, 0, 1'b0, 4, 3, "R4");
    run_case(4, 0, 1'b1, 2, 2, "R4");

    // R6: disable in the middle of a low phase
    @(negedge clk); #1;
    cs_lo = 5'd6; cs_hi = '0; fast = 1'b0; hold_len = 0;
    en = 1'b1;
    while (!scl_low) @(negedge clk);
    @(negedge clk); #1;
    en = 1'b0;
    @(negedge clk);
    chk_eq("R6", "line released after disable", int'(scl_low), 0);
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (scl_low || fall_stb || rise_stb || sample_stb) bad++;
    end
    chk_eq("R6", "activity while disabled", bad, 0);
    // R6 re-enable restarts settling (checked as R5) and runs normally
    run_case(6, 0, 1'b0, 0, 2, "R6");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule